// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using only its fetch address. Two predictors run side by side. The per-branch predictor keeps a short taken/not-taken history for each branch slot and uses that history to pick a 3-bit confidence counter. The path predictor uses a single global shift register of recent outcomes to pick a 2-bit counter. A selector table, indexed by the same global history, decides which of the two answers to use.

Each prediction returns a snapshot that travels with the branch down the pipeline. The snapshot holds both component guesses, the per-branch history that was read, and the global history as it stood before this prediction. When the branch resolves, the snapshot comes back on the update port, so training touches exactly the entries that were read.

The global history is advanced speculatively with each prediction. A resolved mispredict rebuilds it from the snapshot, with the true outcome shifted in. The per-branch history is only advanced at resolve time.

Top module: `tournament_predictor`

## Requirements
- R1: While reset is held, and directly after it, every counter is weakly not-taken and both histories are zero. Every 3-bit counter is 3'b011 and every 2-bit counter is 2'b01. So pred_taken_o, pred_local_o and pred_global_o are 0, and pred_lhist_o and pred_ghist_o are 0.
- R2: A resolve shifts upd_taken_i into bit 0 of the history slot selected by upd_pc_i[PC_LSB +: LHT_IDX_W]. The older bits move up and the oldest bit is dropped. A predict request never changes this table. pred_lhist_o shows the slot selected by pred_pc_i.
- R3: pred_local_o is the MSB of the 3-bit counter indexed by pred_lhist_o. A resolve trains the counter at upd_lhist_i: +1 if taken, -1 if not taken, saturating at 0 and 7.
- R4: pred_global_o is the MSB of the 2-bit counter indexed by pred_ghist_o. A resolve trains the counter at upd_ghist_i the same way, saturating at 0 and 3.
- R5: pred_taken_o equals pred_global_o when the MSB of the selector counter at pred_ghist_o is 1. Otherwise it equals pred_local_o.
- R6: A resolve adds 1 to the selector counter at upd_ghist_i when only the global guess (upd_global_i) matched upd_taken_i. It subtracts 1 when only the local guess (upd_local_i) matched. It is left unchanged when both guesses matched or both missed. The counter saturates at 0 and 3.
- R7: A predict request with no recovery in the same cycle shifts pred_taken_o into bit 0 of the global history on the next edge.
- R8: A resolve with upd_mispred_i set loads the global history with {upd_ghist_i[GH_W-2:0], upd_taken_i}. This takes priority over a predict request in the same cycle. With neither, the global history holds.
- R9: Training uses only the snapshot fields upd_lhist_i and upd_ghist_i for counter and selector indices, whatever the current histories are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | Predict request this cycle |
| pred_pc_i | input | PC_W | Fetch address to predict |
| pred_taken_o | output | 1 | Final direction guess |
| pred_local_o | output | 1 | Per-branch component guess |
| pred_global_o | output | 1 | Path component guess |
| pred_lhist_o | output | LH_W | Per-branch history read for this address |
| pred_ghist_o | output | GH_W | Global history before this prediction |
| upd_valid_i | input | 1 | Resolve a branch this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | True outcome |
| upd_local_i | input | 1 | Per-branch guess from the snapshot |
| upd_global_i | input | 1 | Path guess from the snapshot |
| upd_lhist_i | input | LH_W | Per-branch history from the snapshot |
| upd_ghist_i | input | GH_W | Global history from the snapshot |
| upd_mispred_i | input | 1 | Final guess was wrong; rebuild global history |

## Verification
The hardest case to reach from the ports is a collision in one cycle. A recovery, a new speculative prediction and training of the very counters that prediction reads all land together. Saturation at both ends of every counter must also be reached. The bench drives a small configuration (8 history slots, 4-bit histories), so random addresses collide constantly and counters saturate quickly. In half the cycles it resolves the previous prediction's real snapshot with a random outcome, which produces genuine mispredict recoveries. In the other half it sends arbitrary snapshots, so training indices differ from the live histories. A reference model in the bench checks every output every cycle.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;
  typedef enum logic {SEL_LOCAL = 1'b0, SEL_GLOBAL = 1'b1} tp_sel_e;
endpackage

// File: rtl/tp_ctr_table.sv
`timescale 1ns/1ps
module tp_ctr_table #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_msb_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] WEAK_NT = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur, nxt;

  assign rd_msb_o = mem[rd_idx_i][CTR_W-1];
  assign cur      = mem[wr_idx_i];

  always_comb begin
    nxt = cur;
    if (wr_up_i && cur != CTR_MAX) nxt = cur + 1'b1;
    else if (!wr_up_i && cur != '0) nxt = cur - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= WEAK_NT;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= nxt;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
`timescale 1ns/1ps
module tp_hist_table #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned H_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [H_W-1:0]   rd_hist_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_bit_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [H_W-1:0] mem [DEPTH];

  assign rd_hist_o = mem[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= {mem[wr_idx_i][H_W-2:0], wr_bit_i};
    end
  end
endmodule

// File: rtl/tournament_predictor.sv
`timescale 1ns/1ps
module tournament_predictor
  import tp_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned PC_LSB    = 2,
  parameter int unsigned LHT_IDX_W = 8,
  parameter int unsigned LH_W      = 8,
  parameter int unsigned GH_W      = 10,
  parameter int unsigned LCTR_W    = 3,
  parameter int unsigned GCTR_W    = 2,
  parameter int unsigned CCTR_W    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pred_valid_i,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic            pred_local_o,
  output logic            pred_global_o,
  output logic [LH_W-1:0] pred_lhist_o,
  output logic [GH_W-1:0] pred_ghist_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_local_i,
  input  logic            upd_global_i,
  input  logic [LH_W-1:0] upd_lhist_i,
  input  logic [GH_W-1:0] upd_ghist_i,
  input  logic            upd_mispred_i
);
  logic [GH_W-1:0]      ghist_q;
  logic [LHT_IDX_W-1:0] pred_slot, upd_slot;
  tp_sel_e              sel;
  logic                 sel_msb;
  logic                 chs_en, chs_up;
  logic                 unused_pc;

  assign unused_pc = ^{pred_pc_i, upd_pc_i};
  assign pred_slot = pred_pc_i[PC_LSB +: LHT_IDX_W];
  assign upd_slot  = upd_pc_i[PC_LSB +: LHT_IDX_W];

  tp_hist_table #(.IDX_W(LHT_IDX_W), .H_W(LH_W)) i_lht (
    .clk_i, .rst_ni,
    .rd_idx_i (pred_slot),
    .rd_hist_o(pred_lhist_o),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (upd_slot),
    .wr_bit_i (upd_taken_i)
  );

  tp_ctr_table #(.IDX_W(LH_W), .CTR_W(LCTR_W)) i_lct (
    .clk_i, .rst_ni,
    .rd_idx_i(pred_lhist_o),
    .rd_msb_o(pred_local_o),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(upd_lhist_i),
    .wr_up_i (upd_taken_i)
  );

  tp_ctr_table #(.IDX_W(GH_W), .CTR_W(GCTR_W)) i_gct (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist_q),
    .rd_msb_o(pred_global_o),
    .wr_en_i (upd_valid_i),
    .wr_idx_i(upd_ghist_i),
    .wr_up_i (upd_taken_i)
  );

  // selector moves only when exactly one component was right
  assign chs_en = upd_valid_i && (upd_local_i != upd_global_i);
  assign chs_up = (upd_global_i == upd_taken_i);

  tp_ctr_table #(.IDX_W(GH_W), .CTR_W(CCTR_W)) i_cct (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist_q),
    .rd_msb_o(sel_msb),
    .wr_en_i (chs_en),
    .wr_idx_i(upd_ghist_i),
    .wr_up_i (chs_up)
  );

  assign sel          = tp_sel_e'(sel_msb);
  assign pred_taken_o = (sel == SEL_GLOBAL) ? pred_global_o : pred_local_o;
  assign pred_ghist_o = ghist_q;

  // recovery outranks speculative shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ghist_q <= '0;
    else if (upd_valid_i && upd_mispred_i) ghist_q <= {upd_ghist_i[GH_W-2:0], upd_taken_i};
    else if (pred_valid_i) ghist_q <= {ghist_q[GH_W-2:0], pred_taken_o};
  end
endmodule

// File: rtl/tp_chk.sv
`timescale 1ns/1ps
module tp_chk #(
  parameter int unsigned GH_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pred_valid_i,
  input logic            pred_taken_o,
  input logic            pred_local_o,
  input logic            pred_global_o,
  input logic [GH_W-1:0] pred_ghist_o,
  input logic            upd_valid_i,
  input logic            upd_taken_i,
  input logic [GH_W-1:0] upd_ghist_i,
  input logic            upd_mispred_i
);
  // R7
  spec_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_valid_i && !(upd_valid_i && upd_mispred_i)) |=>
      pred_ghist_o == {$past(pred_ghist_o[GH_W-2:0]), $past(pred_taken_o)});

  // R8
  recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_mispred_i) |=>
      pred_ghist_o == {$past(upd_ghist_i[GH_W-2:0]), $past(upd_taken_i)});

  // R8
  ghist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pred_valid_i && !(upd_valid_i && upd_mispred_i)) |=> $stable(pred_ghist_o));

  // R5
  agree_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_local_o == pred_global_o) |-> (pred_taken_o == pred_local_o));
endmodule

bind tournament_predictor tp_chk #(.GH_W(GH_W)) i_tp_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pred_valid_i (pred_valid_i),
  .pred_taken_o (pred_taken_o),
  .pred_local_o (pred_local_o),
  .pred_global_o(pred_global_o),
  .pred_ghist_o (pred_ghist_o),
  .upd_valid_i  (upd_valid_i),
  .upd_taken_i  (upd_taken_i),
  .upd_ghist_i  (upd_ghist_i),
  .upd_mispred_i(upd_mispred_i)
);

// File: tb/test_tournament_predictor.sv
`timescale 1ns/1ps
module test_tournament_predictor;
  localparam int PC_W = 8, PC_LSB = 2, SW = 3, LH = 4, GH = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pv = 0, uv = 0, ut = 0, ul = 0, ug = 0, um = 0;
  logic [PC_W-1:0] ppc = '0, upc = '0;
  logic [LH-1:0] ulh = '0;
  logic [GH-1:0] ugh = '0;
  logic pt, pl, pg;
  logic [LH-1:0] plh;
  logic [GH-1:0] pgh;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int lht [8];
  int lct [16];
  int gct [16];
  int cct [16];
  int ghr;

  always #5 clk = ~clk;

  tournament_predictor #(.PC_W(PC_W), .PC_LSB(PC_LSB), .LHT_IDX_W(SW), .LH_W(LH),
    .GH_W(GH), .LCTR_W(3), .GCTR_W(2), .CCTR_W(2)) i_tournament_predictor (
    .clk_i(clk), .rst_ni(rst_ni),
    .pred_valid_i(pv), .pred_pc_i(ppc),
    .pred_taken_o(pt), .pred_local_o(pl), .pred_global_o(pg),
    .pred_lhist_o(plh), .pred_ghist_o(pgh),
    .upd_valid_i(uv), .upd_pc_i(upd_pc_w()), .upd_taken_i(ut),
    .upd_local_i(ul), .upd_global_i(ug), .upd_lhist_i(ulh),
    .upd_ghist_i(ugh), .upd_mispred_i(um));

  function automatic logic [PC_W-1:0] upd_pc_w();
    return upc;
  endfunction

  task automatic chk(input string req, input string nm, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  function automatic int sat(input int c, input bit up, input int mx);
    if (up) return (c < mx) ? c + 1 : c;
    return (c > 0) ? c - 1 : c;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) lht[i] = 0;
    for (int i = 0; i < 16; i++) begin lct[i] = 3; gct[i] = 1; cct[i] = 1; end
    ghr = 0;
  endtask

  // expected outputs from model state
  int e_lh, e_l, e_g, e_t;
  task automatic model_out();
    e_lh = lht[(ppc >> PC_LSB) & 7];
    e_l  = lct[e_lh] >> 2;
    e_g  = gct[ghr] >> 1;
    e_t  = (cct[ghr] >> 1) ? e_g : e_l;
  endtask

  task automatic check_all();
    model_out();
    chk("R2", "lhist", plh, e_lh);
    chk("R3 R9", "local", pl, e_l);
    chk("R4 R9", "global", pg, e_g);
    chk("R5 R6", "taken", pt, e_t);
    chk("R7 R8", "ghist", pgh, ghr);
  endtask

  task automatic model_step();
    int nghr;
    model_out();
    nghr = ghr;
    if (uv && um) nghr = ((ugh << 1) | ut) & 15;
    else if (pv) nghr = ((ghr << 1) | e_t) & 15;
    if (uv) begin
      int s;
      s = (upc >> PC_LSB) & 7;
      lht[s] = ((lht[s] << 1) | ut) & 15;
      lct[ulh] = sat(lct[ulh], ut, 7);
      gct[ugh] = sat(gct[ugh], ut, 3);
      if (ul != ug) cct[ugh] = sat(cct[ugh], (ug == ut), 3);
    end
    ghr = nghr;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit lt, ll, lg, have;
    logic [GH-1:0] lgh;
    logic [LH-1:0] llh;
    logic [PC_W-1:0] lpc;
    model_reset();
    // R1: outputs during reset for every slot
    for (int s = 0; s < 8; s++) begin
      ppc = PC_W'(s << PC_LSB);
      #3;
      chk("R1", "taken", pt, 0);
      chk("R1", "local", pl, 0);
      chk("R1", "global", pg, 0);
      chk("R1", "lhist", plh, 0);
      chk("R1", "ghist", pgh, 0);
    end
    @(negedge clk); rst_ni = 1'b1;

    // directed: saturate one path counter up then down (R3 R4)
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      pv = 0; uv = 1; upc = 8'h04; ut = (k < 10); ul = 0; ug = 0; um = 0;
      ulh = 4'h5; ugh = 4'h0; ppc = 8'h04;
      #1; check_all(); model_step();
    end
    // directed: mispredict recovery collides with predict (R8)
    @(negedge clk);
    pv = 1; uv = 1; um = 1; ut = 1; ugh = 4'hA; ul = 1; ug = 0;
    #1; check_all(); model_step();
    @(negedge clk); pv = 0; uv = 0; um = 0;
    #1; chk("R8", "ghist restore", pgh, 4'h5); model_step();

    // mixed random traffic
    have = 0;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      pv  = ($urandom % 4) != 0;
      ppc = PC_W'($urandom);
      if ((n % 2) == 0 && have) begin
        uv = 1; upc = lpc; ut = $urandom % 2; ul = ll; ug = lg;
        ulh = llh; ugh = lgh; um = (ut != lt);
      end else begin
        uv = $urandom % 2; upc = PC_W'($urandom); ut = $urandom % 2;
        ul = $urandom % 2; ug = $urandom % 2; ulh = LH'($urandom);
        ugh = GH'($urandom); um = ($urandom % 4) == 0;
      end
      #1;
      check_all();
      lt = pt; ll = pl; lg = pg; llh = plh; lgh = pgh; lpc = ppc; have = pv;
      model_step();
    end
    @(negedge clk); pv = 0; uv = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule